// File: doc/BRIEF.md
# Peripheral Register Space Decoder

This block sits between a processor's load/store and I/O-instruction path and a 64-location peripheral register space. It turns each access into a one-hot select strobe for the addressed location, returns the location's contents, and applies the write. Dedicated I/O instructions address the space directly at 0x00 to 0x3F. Ordinary data-space loads and stores reach the same locations through a second window that starts 0x20 higher.

Single-bit set, clear and test operations work only in the lower 32 locations. A set or clear reads the whole byte, changes the one bit picked by a 3-bit index, and writes the whole byte back, all in one cycle. Status flags are write-one-to-clear. Because a bit operation writes back the full byte, it clears every flag that currently reads as set. A bit operation aimed above the bit window raises an illegal-access indication and does nothing else.

Four example locations exercise the decoder:
- a plain byte at I/O 0x05;
- a byte at 0x0A whose upper four bits are reserved;
- a write-one-to-clear flag byte at 0x0C, set by hardware;
- a plain byte at 0x30, above the bit window.

Every other location is reserved.

Top module: `iosp_decoder`

## Requirements
- R1: With acc_valid high, kinds 0 (I/O read) and 1 (I/O write) at an address below 0x40 drive sel bit [addr] alone. Any address of 0x40 or above selects nothing. With acc_valid low, nothing is selected or written, and sel always has at most one bit set.
- R2: Kinds 2 (data read) and 3 (data write) decode addresses 0x20 to 0x5F to location addr-0x20. Data addresses below 0x20 or above 0x5F select nothing and change nothing.
- R3: Kind 4 (bit set) sets bit acc_bit of the addressed byte and leaves the other bits of a plain register unchanged. The change is visible from the next cycle.
- R4: Kind 5 (bit clear) clears bit acc_bit of the addressed byte and leaves the other bits of a plain register unchanged.
- R5: Kind 6 (bit test) returns bit acc_bit of the addressed byte on bit_result in the same cycle and changes no state. bit_result is 0 for every other kind.
- R6: A kind 4, 5 or 6 access at an address of 0x20 or above sets illegal in that cycle, selects nothing and changes no state. illegal is 0 for all other accesses.
- R7: In the flag byte (0x0C), writing a 1 to a bit clears it and writing a 0 leaves it unchanged.
- R8: A bit of flag_hw_set sets the matching flag on the next edge, and wins over a clear in the same cycle.
- R9: A bit set or bit clear on the flag byte writes back the full modified byte, so every other flag that read as 1 is cleared.
- R10: Reserved locations read as 0 and ignore writes and bit operations. The reserved upper nibble of 0x0A reads as 0.
- R11: Reset clears all example registers to 0.
- R12: rd_data shows the addressed location's current contents for any hit access, written values appearing from the next cycle, and is 0 when nothing is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_kind | input | 3 | Access kind code 0..6 (7 = no operation) |
| acc_addr | input | 8 | I/O or data-space address |
| acc_wdata | input | 8 | Write data for byte writes |
| acc_bit | input | 3 | Bit index for bit operations |
| flag_hw_set | input | 8 | Hardware set of the flag byte bits |
| rd_data | output | 8 | Current contents of the addressed location |
| bit_result | output | 1 | Tested bit for bit-test accesses |
| sel | output | 64 | One-hot location select strobe |
| illegal | output | 1 | Bit operation outside the bit window |

## Verification
The stability checks assume that flag_hw_set is quiet whenever a bit test or an illegal bit operation is presented. Otherwise a legitimate hardware set would change state in that cycle. The stimulus table keeps flag_hw_set at zero on every such row and raises it only alongside plain reads and writes. Inputs change only on the falling edge, so each access is seen whole at the next rising edge.

// File: rtl/iosp_pkg.sv
package iosp_pkg;
  typedef enum logic [2:0] {
    K_IO_RD = 3'd0,
    K_IO_WR = 3'd1,
    K_DS_RD = 3'd2,
    K_DS_WR = 3'd3,
    K_BSET  = 3'd4,
    K_BCLR  = 3'd5,
    K_BTST  = 3'd6,
    K_NONE  = 3'd7
  } acc_kind_e;
endpackage

// File: rtl/iosp_addr_map.sv
module iosp_addr_map
  import iosp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_LOC   = 64,
  parameter int DS_OFFSET = 32,
  parameter int BIT_LIMIT = 32,
  localparam int IDX_W    = $clog2(NUM_LOC)
) (
  input  logic              valid,
  input  acc_kind_e         kind,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic              is_write,
  output logic              is_bitop,
  output logic              is_test,
  output logic              illegal
);
  localparam logic [ADDR_W-1:0] IO_LIM  = ADDR_W'(NUM_LOC);
  localparam logic [ADDR_W-1:0] DS_LO   = ADDR_W'(DS_OFFSET);
  localparam logic [ADDR_W-1:0] DS_HI   = ADDR_W'(DS_OFFSET + NUM_LOC);
  localparam logic [ADDR_W-1:0] BIT_LIM = ADDR_W'(BIT_LIMIT);

  logic              in_rng;
  logic              bit_kind;
  logic [ADDR_W-1:0] loc;

  always_comb begin
    in_rng   = 1'b0;
    bit_kind = 1'b0;
    loc      = addr;
    is_write = 1'b0;
    is_bitop = 1'b0;
    is_test  = 1'b0;
    case (kind)
      K_IO_RD: in_rng = (addr < IO_LIM);
      K_IO_WR: begin
        in_rng   = (addr < IO_LIM);
        is_write = 1'b1;
      end
      K_DS_RD: begin
        in_rng = (addr >= DS_LO) && (addr < DS_HI);
        loc    = addr - DS_LO;
      end
      K_DS_WR: begin
        in_rng   = (addr >= DS_LO) && (addr < DS_HI);
        loc      = addr - DS_LO;
        is_write = 1'b1;
      end
      K_BSET, K_BCLR: begin
        in_rng   = (addr < BIT_LIM);
        bit_kind = 1'b1;
        is_write = 1'b1;
        is_bitop = 1'b1;
      end
      K_BTST: begin
        in_rng   = (addr < BIT_LIM);
        bit_kind = 1'b1;
        is_test  = 1'b1;
      end
      default: in_rng = 1'b0;
    endcase
    hit     = valid & in_rng;
    idx     = loc[IDX_W-1:0];
    illegal = valid & bit_kind & ~in_rng;
  end
endmodule

// File: rtl/iosp_bitop.sv
module iosp_bitop #(
  parameter int DW     = 8,
  localparam int BIT_W = $clog2(DW)
) (
  input  logic [DW-1:0]    old_byte,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             set_bit,
  output logic [DW-1:0]    new_byte,
  output logic             test_bit
);
  logic [DW-1:0] one_hot;

  always_comb begin
    one_hot  = DW'(1) << bit_idx;
    new_byte = set_bit ? (old_byte | one_hot) : (old_byte & ~one_hot);
    test_bit = old_byte[bit_idx];
  end
endmodule

// File: rtl/iosp_reg.sv
module iosp_reg #(
  parameter int            DW   = 8,
  parameter logic [DW-1:0] MASK = '1,
  parameter bit            W1C  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_set,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_r;
  logic [DW-1:0] nxt;
  logic          en;

  generate
    if (W1C) begin : g_w1c
      always_comb nxt = ((q_r & ~(we ? wdata : '0)) | hw_set) & MASK;

      a_r8_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_set & MASK)) |=> ((q_r & $past(hw_set & MASK)) == $past(hw_set & MASK)));
      a_r7_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set == '0) |=> ((q_r & ~$past(q_r)) == '0));
    end else begin : g_plain
      always_comb nxt = ((we ? wdata : q_r) | hw_set) & MASK;

      a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && hw_set == '0) |=> $stable(q_r));
    end
  endgenerate

  always_comb en = we | (|hw_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (en) q_r <= nxt;
  end

  always_comb q = q_r;

  a_r10_reserved_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q_r & ~MASK) == '0));
endmodule

// File: rtl/iosp_decoder.sv
module iosp_decoder
  import iosp_pkg::*;
#(
  parameter int            ADDR_W      = 8,
  parameter int            DW          = 8,
  parameter int            NUM_LOC     = 64,
  parameter int            DS_OFFSET   = 32,
  parameter int            BIT_LIMIT   = 32,
  parameter int            SCRATCH_ADR = 5,
  parameter int            CTRL_ADR    = 10,
  parameter logic [DW-1:0] CTRL_MASK   = 8'h0F,
  parameter int            FLAG_ADR    = 12,
  parameter int            HIGH_ADR    = 48,
  localparam int           IDX_W       = $clog2(NUM_LOC),
  localparam int           BIT_W       = $clog2(DW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [2:0]         acc_kind,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [DW-1:0]      acc_wdata,
  input  logic [BIT_W-1:0]   acc_bit,
  input  logic [DW-1:0]      flag_hw_set,
  output logic [DW-1:0]      rd_data,
  output logic               bit_result,
  output logic [NUM_LOC-1:0] sel,
  output logic               illegal
);
  localparam int NREG = 4;
  localparam int            REG_ADR [NREG] = '{SCRATCH_ADR, CTRL_ADR, FLAG_ADR, HIGH_ADR};
  localparam logic [DW-1:0] REG_MSK [NREG] = '{{DW{1'b1}}, CTRL_MASK, {DW{1'b1}}, {DW{1'b1}}};
  localparam bit            REG_W1C [NREG] = '{1'b0, 1'b0, 1'b1, 1'b0};

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             is_write;
  logic             is_bitop;
  logic             is_test;
  logic             ill_w;
  logic [DW-1:0]    cur;
  logic [DW-1:0]    bit_new;
  logic             tbit;
  logic [DW-1:0]    wbyte;
  logic [NUM_LOC-1:0]        sel_w;
  logic [NREG-1:0][DW-1:0]   q_all;

  iosp_addr_map #(
    .ADDR_W(ADDR_W), .NUM_LOC(NUM_LOC), .DS_OFFSET(DS_OFFSET), .BIT_LIMIT(BIT_LIMIT)
  ) u_map (
    .valid(acc_valid), .kind(acc_kind_e'(acc_kind)), .addr(acc_addr),
    .hit(hit), .idx(idx), .is_write(is_write), .is_bitop(is_bitop),
    .is_test(is_test), .illegal(ill_w)
  );

  generate
    for (genvar i = 0; i < NUM_LOC; i++) begin : g_sel
      assign sel_w[i] = hit && (idx == IDX_W'(i));
    end
  endgenerate

  always_comb begin
    cur = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel_w[REG_ADR[i]]) cur = cur | q_all[i];
    end
  end

  iosp_bitop #(.DW(DW)) u_bitop (
    .old_byte(cur), .bit_idx(acc_bit), .set_bit(acc_kind_e'(acc_kind) == K_BSET),
    .new_byte(bit_new), .test_bit(tbit)
  );

  always_comb wbyte = is_bitop ? bit_new : acc_wdata;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      iosp_reg #(.DW(DW), .MASK(REG_MSK[i]), .W1C(REG_W1C[i])) u_reg (
        .clk(clk), .rst_n(rst_n),
        .we(is_write & sel_w[REG_ADR[i]]),
        .wdata(wbyte),
        .hw_set(REG_W1C[i] ? flag_hw_set : '0),
        .q(q_all[i])
      );
    end
  endgenerate

  always_comb begin
    sel        = sel_w;
    rd_data    = cur;
    bit_result = hit & is_test & tbit;
    illegal    = ill_w;
  end

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  a_r6_illegal_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (sel == '0));
  a_r6_illegal_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && flag_hw_set == '0) |=> $stable(q_all));
  a_r5_test_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 3'd6 && flag_hw_set == '0) |=> $stable(q_all));
  a_r12_no_hit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> (rd_data == '0 && bit_result == 1'b0));
endmodule

// File: tb/iosp_decoder_tb.sv
module iosp_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 40;
  localparam logic [2:0] IORD = 3'd0, IOWR = 3'd1, DSRD = 3'd2, DSWR = 3'd3,
                         BSET = 3'd4, BCLR = 3'd5, BTST = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [2:0]  acc_kind;
  logic [7:0]  acc_addr;
  logic [7:0]  acc_wdata;
  logic [2:0]  acc_bit;
  logic [7:0]  flag_hw_set;
  logic [7:0]  rd_data;
  logic        bit_result;
  logic [63:0] sel;
  logic        illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iosp_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_bit(acc_bit),
    .flag_hw_set(flag_hw_set), .rd_data(rd_data), .bit_result(bit_result),
    .sel(sel), .illegal(illegal)
  );

  // fields: req, kind, addr, wdata, bit, hw_set, exp rd, exp bit, exp illegal
  localparam logic [43:0] VEC [NV] = '{
    {4'd12, IORD, 8'h05, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R12
    {4'd1,  IOWR, 8'h05, 8'hA5, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R1
    {4'd2,  DSRD, 8'h25, 8'h00, 3'd0, 8'h00, 8'hA5, 1'b0, 1'b0}, // R2
    {4'd2,  DSWR, 8'h25, 8'h3C, 3'd0, 8'h00, 8'hA5, 1'b0, 1'b0}, // R2
    {4'd2,  IORD, 8'h05, 8'h00, 3'd0, 8'h00, 8'h3C, 1'b0, 1'b0}, // R2
    {4'd3,  BSET, 8'h05, 8'h00, 3'd0, 8'h00, 8'h3C, 1'b0, 1'b0}, // R3
    {4'd4,  BCLR, 8'h05, 8'h00, 3'd5, 8'h00, 8'h3D, 1'b0, 1'b0}, // R4
    {4'd5,  BTST, 8'h05, 8'h00, 3'd4, 8'h00, 8'h1D, 1'b1, 1'b0}, // R5
    {4'd5,  BTST, 8'h05, 8'h00, 3'd5, 8'h00, 8'h1D, 1'b0, 1'b0}, // R5
    {4'd5,  IORD, 8'h05, 8'h00, 3'd0, 8'h00, 8'h1D, 1'b0, 1'b0}, // R5
    {4'd10, IOWR, 8'h0A, 8'hFF, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R10
    {4'd10, IORD, 8'h0A, 8'h00, 3'd0, 8'h00, 8'h0F, 1'b0, 1'b0}, // R10
    {4'd10, IOWR, 8'h01, 8'h77, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R10
    {4'd10, IORD, 8'h01, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R10
    {4'd10, BSET, 8'h01, 8'h00, 3'd3, 8'h00, 8'h00, 1'b0, 1'b0}, // R10
    {4'd10, IORD, 8'h01, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R10
    {4'd1,  IOWR, 8'h30, 8'h99, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R1
    {4'd2,  DSRD, 8'h50, 8'h00, 3'd0, 8'h00, 8'h99, 1'b0, 1'b0}, // R2
    {4'd6,  BSET, 8'h30, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b1}, // R6
    {4'd6,  IORD, 8'h30, 8'h00, 3'd0, 8'h00, 8'h99, 1'b0, 1'b0}, // R6
    {4'd2,  DSRD, 8'h05, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R2
    {4'd2,  DSWR, 8'h60, 8'hFF, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R2
    {4'd1,  IORD, 8'h45, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R1
    {4'd8,  IORD, 8'h0C, 8'h00, 3'd0, 8'h05, 8'h00, 1'b0, 1'b0}, // R8
    {4'd8,  IORD, 8'h0C, 8'h00, 3'd0, 8'h00, 8'h05, 1'b0, 1'b0}, // R8
    {4'd7,  IOWR, 8'h0C, 8'h00, 3'd0, 8'h00, 8'h05, 1'b0, 1'b0}, // R7
    {4'd7,  IORD, 8'h0C, 8'h00, 3'd0, 8'h00, 8'h05, 1'b0, 1'b0}, // R7
    {4'd7,  IOWR, 8'h0C, 8'h04, 3'd0, 8'h00, 8'h05, 1'b0, 1'b0}, // R7
    {4'd7,  IORD, 8'h0C, 8'h00, 3'd0, 8'h00, 8'h01, 1'b0, 1'b0}, // R7
    {4'd8,  IOWR, 8'h0C, 8'h01, 3'd0, 8'h01, 8'h01, 1'b0, 1'b0}, // R8
    {4'd8,  IORD, 8'h0C, 8'h00, 3'd0, 8'h00, 8'h01, 1'b0, 1'b0}, // R8
    {4'd8,  DSWR, 8'h2C, 8'hFF, 3'd0, 8'h06, 8'h01, 1'b0, 1'b0}, // R8
    {4'd8,  IORD, 8'h0C, 8'h00, 3'd0, 8'h00, 8'h06, 1'b0, 1'b0}, // R8
    {4'd9,  BSET, 8'h0C, 8'h00, 3'd0, 8'h00, 8'h06, 1'b0, 1'b0}, // R9
    {4'd9,  IORD, 8'h0C, 8'h00, 3'd0, 8'h0A, 8'h00, 1'b0, 1'b0}, // R9
    {4'd9,  BCLR, 8'h0C, 8'h00, 3'd1, 8'h00, 8'h0A, 1'b0, 1'b0}, // R9
    {4'd9,  IORD, 8'h0C, 8'h00, 3'd0, 8'h00, 8'h02, 1'b0, 1'b0}, // R9
    {4'd5,  BTST, 8'h0C, 8'h00, 3'd1, 8'h00, 8'h02, 1'b1, 1'b0}, // R5
    {4'd5,  IORD, 8'h0C, 8'h00, 3'd0, 8'h00, 8'h02, 1'b0, 1'b0}, // R5
    {4'd6,  BTST, 8'h20, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b1}  // R6
  };

  task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] k, input logic [7:0] a,
                       input logic [7:0] wd, input logic [2:0] b, input logic [7:0] hw);
    @(negedge clk);
    acc_valid = v; acc_kind = k; acc_addr = a; acc_wdata = wd;
    acc_bit = b; flag_hw_set = hw;
    #(CLK_PERIOD/4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    acc_valid = 1'b0; acc_kind = 3'd7; acc_addr = '0; acc_wdata = '0;
    acc_bit = '0; flag_hw_set = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11: reset contents of every example location
    drive(1, IORD, 8'h05, 0, 0, 0); check(11, rd_data, 8'h00, "reset 0x05");
    drive(1, IORD, 8'h0A, 0, 0, 0); check(11, rd_data, 8'h00, "reset 0x0A");
    drive(1, IORD, 8'h0C, 0, 0, 0); check(11, rd_data, 8'h00, "reset 0x0C");
    drive(1, IORD, 8'h30, 0, 0, 0); check(11, rd_data, 8'h00, "reset 0x30");

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      drive(1'b1, v[39:37], v[36:29], v[28:21], v[20:18], v[17:10]);
      check(int'(v[43:40]), {rd_data, bit_result, illegal}, {v[9:2], v[1], v[0]},
            $sformatf("vector %0d {rd,bit,illegal}", i));
    end

    // R1: select strobes and the valid qualifier
    drive(1, IORD, 8'h05, 0, 0, 0); check(1, sel, 64'h1 << 5, "sel io 0x05");
    drive(1, IORD, 8'h3F, 0, 0, 0); check(1, sel, 64'h1 << 63, "sel io 0x3F");
    drive(1, IORD, 8'h40, 0, 0, 0); check(1, sel, 64'h0, "sel io 0x40");
    drive(0, IOWR, 8'h05, 8'hFF, 0, 0); check(1, sel, 64'h0, "sel when invalid");
    drive(1, IORD, 8'h05, 0, 0, 0); check(1, rd_data, 8'h1D, "write while invalid");
    // R2: data-window edges
    drive(1, DSRD, 8'h20, 0, 0, 0); check(2, sel, 64'h1, "sel ds 0x20");
    drive(1, DSRD, 8'h5F, 0, 0, 0); check(2, sel, 64'h1 << 63, "sel ds 0x5F");
    drive(1, DSRD, 8'h1F, 0, 0, 0); check(2, sel, 64'h0, "sel ds 0x1F");
    // R6: illegal bit operation selects nothing, boundary 0x1F legal
    drive(1, BCLR, 8'h30, 0, 3'd0, 0); check(6, {sel, illegal}, {64'h0, 1'b1}, "bclr 0x30");
    drive(1, DSRD, 8'h50, 0, 0, 0); check(6, rd_data, 8'h99, "0x30 unchanged");
    drive(1, BTST, 8'h1F, 0, 0, 0); check(6, {sel, illegal}, {64'h1 << 31, 1'b0}, "btst 0x1F");
    drive(1, IORD, 8'h30, 0, 0, 0); check(6, illegal, 1'b0, "illegal on io read");
    // R3 / R4: top bit of a plain register
    drive(1, BSET, 8'h05, 0, 3'd7, 0);
    drive(1, IORD, 8'h05, 0, 0, 0); check(3, rd_data, 8'h9D, "bset bit7");
    drive(1, BCLR, 8'h05, 0, 3'd0, 0);
    drive(1, IORD, 8'h05, 0, 0, 0); check(4, rd_data, 8'h9C, "bclr bit0");

    // R11: asynchronous reset mid-run
    @(negedge clk) rst_n = 1'b0;
    #(CLK_PERIOD/4);
    check(11, {u_dut.rd_data}, 8'h00, "rd during reset");
    @(negedge clk) rst_n = 1'b1;
    drive(1, IORD, 8'h05, 0, 0, 0); check(11, rd_data, 8'h00, "0x05 after reset");
    drive(1, IORD, 8'h30, 0, 0, 0); check(11, rd_data, 8'h00, "0x30 after reset");

    drive(0, 3'd7, 0, 0, 0, 0);
    finish_run();
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule